// File: doc/BRIEF.md
# Fast-Page DRAM Burst Sequencer

This block sits between a CPU bus and an array of fast-page-mode DRAM. It accepts one CPU access at a time. Each access is a single transfer or a burst of four quadwords. The block drives the row strobe, the column strobe, the write strobe and a multiplexed row/column address. Every edge falls on a fixed clock count.

The block remembers which row is left open. It sorts each access into one of three classes: a page hit (the same row is open), a row miss (no row is open) or a page miss (another row is open). The class sets the leadoff. Two mode inputs change the schedule. Posted writes let the CPU finish a write early while the DRAM write runs behind it. Closed-row mode precharges after every access and uses one flat schedule.

Between CPU accesses the block runs refresh sequences on request. There are three kinds, each run once or four times in a row.

Cycle numbering used throughout: cycle 1 is the clock cycle at whose closing edge the block takes a request. Cycle 2 is the next cycle, and so on.

Top module: `dram_burst_sequencer`

## Requirements
- R1: After reset all strobes (`dram_ras_n`, `dram_cas_n`, `dram_we_n`) are high, `cpu_rdy` and `rfsh_ack` are low, and no row counts as open.
- R2: A read gives its first `cpu_rdy` in cycle 6 on a page hit, cycle 10 on a row miss and cycle 12 on a page miss. Page hit means a row is open and equals the request's row. Row miss means no row is open. Page miss means a different row is open.
- R3: A non-posted write gives its first `cpu_rdy` in cycle 10, 11 or 13 for a page hit, row miss or page miss.
- R4: With `cpu_burst`=1 the three later beats follow at 3-clock spacing; with `cpu_burst`=0 there is one beat at the same leadoff. `dram_cas_n` is low for exactly the one cycle of each beat.
- R5: With `posted_en`=1 a write raises `cpu_rdy` in cycles 4, 5, 6, 7 (only cycle 4 for a single). The DRAM column strobes still follow the write schedule of R3 or R6.
- R6: With `closed_row_en`=1 reads and writes use leadoff 9. `dram_ras_n` falls in cycle 4 and rises in the cycle after the last beat. The next access finds no row open.
- R7: On a page hit `dram_ras_n` stays low throughout. On a row or page miss it falls in cycle leadoff−4. A page miss first raises it from cycle 2 to precharge. In open-row mode the row stays strobed after the access.
- R8: Beat k of a burst uses column {`cpu_addr` column[11:2], column[1:0] XOR k}. This is the interleaved order, starting at the requested quadword. Column is `cpu_addr`[11:0] and row is `cpu_addr`[23:12].
- R9: `dram_ma` carries the row from cycle 2 until one clock before the first column strobe. Each column appears exactly one clock before its strobe and holds through it.
- R10: `rfsh_kind` encodes 0 hidden, 1 RAS-only, 2 or 3 CAS-before-RAS. A single refresh pulses `rfsh_ack` in cycle 16, 17 or 18 respectively and returns to idle the cycle after.
- R11: With `rfsh_four`=1 the sequence repeats four times, and `rfsh_ack` pulses once, in cycle 64, 68 or 72.
- R12: A CPU request seen during a refresh gets no `cpu_rdy` until the refresh ends. The block takes it in the cycle after `rfsh_ack`, and it sees no open row.
- R13: In a refresh of length D, `dram_ras_n` is low in cycles 3 to D−4 of the first sequence. CAS-before-RAS pulls `dram_cas_n` low from cycle 2 to D−4. The other kinds keep `dram_cas_n` high.
- R14: `dram_we_n` is low from cycle 2 through the last column strobe of a write, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, taken when idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_burst | input | 1 | 1 = burst of four, 0 = single |
| cpu_addr | input | 24 | Row in [23:12], column in [11:0] |
| posted_en | input | 1 | Posted-write mode select |
| closed_row_en | input | 1 | Closed-row mode select |
| cpu_rdy | output | 1 | Data beat ready to the CPU |
| rfsh_req | input | 1 | Refresh request, held until acknowledged |
| rfsh_kind | input | 2 | Refresh kind |
| rfsh_four | input | 1 | 1 = four refreshes back to back |
| rfsh_ack | output | 1 | Last cycle of a refresh sequence |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_ma | output | 12 | Multiplexed row/column address |

## Verification
Every result is due on a fixed cycle counted from the cycle in which the request is taken. The first ready comes at the leadoff, later beats every 3 clocks after it, and the posted ready at cycles 4 to 7. The row strobe falls at leadoff−4 (4 when closed), each column appears one clock before its strobe, and the refresh acknowledge comes at its kind's cost. The bench keeps its own model of the open row and derives each leadoff from it. It then samples every output on the falling edge of every cycle from cycle 2 to the cycle after the last beat. Any cycle where a strobe, ready or address differs from the computed schedule counts against that access. This catches edges that come early or late by a single clock as well as missing ones.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

    localparam int unsigned CNT_W = 8;

    typedef enum logic [1:0] {
        CLS_HIT      = 2'd0,
        CLS_ROWMISS  = 2'd1,
        CLS_PAGEMISS = 2'd2
    } acc_class_e;

    localparam logic [CNT_W-1:0] CK_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] CK_TWO   = CNT_W'(2);
    localparam logic [CNT_W-1:0] CK_GAP   = CNT_W'(3);
    localparam logic [CNT_W-1:0] CK_FOUR  = CNT_W'(4);
    localparam logic [CNT_W-1:0] CK_FIVE  = CNT_W'(5);
    localparam logic [CNT_W-1:0] POST_AT  = CNT_W'(4);

    // first-beat cycle for an access, counted from the accepting cycle as 1
    function automatic logic [CNT_W-1:0] leadoff(input logic wr, input acc_class_e c,
                                                 input logic closed);
        if (closed) return CNT_W'(9);
        case (c)
            CLS_HIT:     return wr ? CNT_W'(10) : CNT_W'(6);
            CLS_ROWMISS: return wr ? CNT_W'(11) : CNT_W'(10);
            default:     return wr ? CNT_W'(13) : CNT_W'(12);
        endcase
    endfunction

    // length of one refresh sequence for a kind code
    function automatic logic [CNT_W-1:0] refresh_len(input logic [1:0] kind);
        case (kind)
            2'd0:    return CNT_W'(16);
            2'd1:    return CNT_W'(17);
            default: return CNT_W'(18);
        endcase
    endfunction

endpackage

// File: rtl/dbs_open_row.sv
module dbs_open_row import dbs_pkg::*; #(
    parameter int unsigned ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set,
    input  logic             clear,
    input  logic             closed,
    input  logic [ROW_W-1:0] row_in,
    output acc_class_e       cls
);
    logic             valid_q;
    logic [ROW_W-1:0] open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            open_q  <= '0;
        end else if (clear) begin
            valid_q <= 1'b0;
        end else if (set) begin
            valid_q <= !closed;
            open_q  <= row_in;
        end
    end

    always_comb begin
        if (!valid_q)              cls = CLS_ROWMISS;
        else if (open_q == row_in) cls = CLS_HIT;
        else                       cls = CLS_PAGEMISS;
    end
endmodule

// File: rtl/dbs_cpu_timer.sv
module dbs_cpu_timer import dbs_pkg::*; #(
    parameter int unsigned MA_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             ras_clear,
    input  logic [CNT_W-1:0] lead,
    input  logic [CNT_W-1:0] ras_at,
    input  logic [1:0]       last_beat,
    input  logic             posted,
    input  logic             wr,
    input  logic             ras_keep,
    input  logic             closed,
    input  logic [MA_W-1:0]  row,
    input  logic [MA_W-1:0]  col,
    output logic             active,
    output logic             rdy,
    output logic             cas_low,
    output logic             ras_low,
    output logic             wr_active,
    output logic [MA_W-1:0]  ma
);
    logic             active_q, col_on, ras_low_q, posted_q, wr_q, closed_q;
    logic [CNT_W-1:0] tcyc, cas_at, ras_at_q, post_last;
    logic [1:0]       bidx, lastb;
    logic [MA_W-1:0]  row_q, col_q;
    logic             beat_now;

    assign beat_now  = active_q && col_on && (tcyc == cas_at);
    assign post_last = POST_AT + CNT_W'(lastb);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= 1'b0;
            col_on    <= 1'b0;
            ras_low_q <= 1'b0;
            posted_q  <= 1'b0;
            wr_q      <= 1'b0;
            closed_q  <= 1'b0;
            tcyc      <= '0;
            cas_at    <= '0;
            ras_at_q  <= '0;
            bidx      <= '0;
            lastb     <= '0;
            row_q     <= '0;
            col_q     <= '0;
        end else if (start) begin
            active_q  <= 1'b1;
            col_on    <= 1'b0;
            ras_low_q <= ras_keep;
            posted_q  <= posted;
            wr_q      <= wr;
            closed_q  <= closed;
            tcyc      <= CK_TWO;
            cas_at    <= lead;
            ras_at_q  <= ras_at;
            bidx      <= '0;
            lastb     <= last_beat;
            row_q     <= row;
            col_q     <= col;
        end else begin
            if (ras_clear) ras_low_q <= 1'b0;
            if (active_q) begin
                tcyc <= tcyc + CK_ONE;
                if (tcyc == ras_at_q - CK_ONE) ras_low_q <= 1'b1;
                // column goes out one clock ahead of its strobe
                if (!col_on && tcyc == cas_at - CK_TWO) col_on <= 1'b1;
                if (col_on && tcyc == cas_at + CK_ONE && bidx != lastb) begin
                    bidx   <= bidx + 2'd1;
                    cas_at <= cas_at + CK_GAP;
                end
                if (beat_now && bidx == lastb) begin
                    active_q <= 1'b0;
                    if (closed_q) ras_low_q <= 1'b0;
                end
            end
        end
    end

    assign active    = active_q;
    assign cas_low   = beat_now;
    assign ras_low   = ras_low_q;
    assign wr_active = active_q && wr_q;
    assign rdy       = posted_q ? (active_q && tcyc >= POST_AT && tcyc <= post_last) : beat_now;
    assign ma        = col_on ? {col_q[MA_W-1:2], col_q[1:0] ^ bidx} : row_q;
endmodule

// File: rtl/dbs_refresh_engine.sv
module dbs_refresh_engine import dbs_pkg::*; #(
    parameter int unsigned MA_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [1:0]      kind,
    input  logic            four,
    output logic            active,
    output logic            ras_low,
    output logic            cas_low,
    output logic            ack,
    output logic [MA_W-1:0] ma
);
    logic             active_q, cbr_q;
    logic [CNT_W-1:0] rp, dlen;
    logic [1:0]       unit, last_unit;
    logic [MA_W-1:0]  rrow;

    assign ack = active_q && (unit == last_unit) && (rp == dlen - CK_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q  <= 1'b0;
            cbr_q     <= 1'b0;
            rp        <= '0;
            dlen      <= '0;
            unit      <= '0;
            last_unit <= '0;
            rrow      <= '0;
        end else if (start) begin
            active_q  <= 1'b1;
            cbr_q     <= kind[1];
            rp        <= CK_ONE;
            dlen      <= refresh_len(kind);
            unit      <= '0;
            last_unit <= four ? 2'd3 : 2'd0;
        end else if (active_q) begin
            if (ack) begin
                active_q <= 1'b0;
                rrow     <= rrow + MA_W'(1);
            end else if (rp == dlen - CK_ONE) begin
                rp   <= '0;
                unit <= unit + 2'd1;
                rrow <= rrow + MA_W'(1);
            end else begin
                rp <= rp + CK_ONE;
            end
        end
    end

    assign active  = active_q;
    assign ras_low = active_q && rp >= CK_TWO && rp < dlen - CK_FOUR;
    assign cas_low = active_q && cbr_q && rp >= CK_ONE && rp < dlen - CK_FOUR;
    assign ma      = rrow;

    assert_single_ack_R10: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);
endmodule

// File: rtl/dram_burst_sequencer.sv
module dram_burst_sequencer import dbs_pkg::*; #(
    parameter int unsigned MA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_burst,
    input  logic [2*MA_W-1:0] cpu_addr,
    input  logic              posted_en,
    input  logic              closed_row_en,
    output logic              cpu_rdy,
    input  logic              rfsh_req,
    input  logic [1:0]        rfsh_kind,
    input  logic              rfsh_four,
    output logic              rfsh_ack,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [MA_W-1:0]   dram_ma
);
    logic [MA_W-1:0]  req_row, req_col, cpu_ma, rf_ma;
    logic             cpu_active, cpu_cas, cpu_ras, cpu_wr;
    logic             rf_active, rf_ras, rf_cas;
    logic             idle, rf_start, cpu_start;
    acc_class_e       cls;
    logic [CNT_W-1:0] lead, ras_at;

    assign req_row   = cpu_addr[2*MA_W-1:MA_W];
    assign req_col   = cpu_addr[MA_W-1:0];
    assign idle      = !cpu_active && !rf_active;
    assign rf_start  = idle && rfsh_req;
    assign cpu_start = idle && !rfsh_req && cpu_req;

    assign lead   = leadoff(cpu_we, cls, closed_row_en);
    assign ras_at = closed_row_en ? lead - CK_FIVE :
                    (cls == CLS_HIT) ? '0 : lead - CK_FOUR;

    dbs_open_row #(.ROW_W(MA_W)) u_row (
        .clk(clk), .rst(rst), .set(cpu_start), .clear(rf_start),
        .closed(closed_row_en), .row_in(req_row), .cls(cls)
    );

    dbs_cpu_timer #(.MA_W(MA_W)) u_cpu (
        .clk(clk), .rst(rst), .start(cpu_start), .ras_clear(rf_start),
        .lead(lead), .ras_at(ras_at),
        .last_beat(cpu_burst ? 2'd3 : 2'd0),
        .posted(posted_en && cpu_we), .wr(cpu_we),
        .ras_keep(!closed_row_en && cls == CLS_HIT), .closed(closed_row_en),
        .row(req_row), .col(req_col),
        .active(cpu_active), .rdy(cpu_rdy), .cas_low(cpu_cas), .ras_low(cpu_ras),
        .wr_active(cpu_wr), .ma(cpu_ma)
    );

    dbs_refresh_engine #(.MA_W(MA_W)) u_rf (
        .clk(clk), .rst(rst), .start(rf_start), .kind(rfsh_kind), .four(rfsh_four),
        .active(rf_active), .ras_low(rf_ras), .cas_low(rf_cas), .ack(rfsh_ack),
        .ma(rf_ma)
    );

    assign dram_ras_n = !(rf_active ? rf_ras : cpu_ras);
    assign dram_cas_n = !(cpu_cas || rf_cas);
    assign dram_we_n  = !cpu_wr;
    assign dram_ma    = rf_active ? rf_ma : cpu_ma;

    assert_quiet_in_refresh_R12: assert property (@(posedge clk) disable iff (rst)
        rf_active |-> !cpu_rdy);
    assert_cas_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_active && !dram_cas_n) |=> dram_cas_n);
    assert_cas_under_ras_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_active && !dram_cas_n) |-> !dram_ras_n);
    assert_we_in_access_R14: assert property (@(posedge clk) disable iff (rst)
        !dram_we_n |-> cpu_active);
endmodule

// File: tb/dram_burst_sequencer_test.sv
module dram_burst_sequencer_test;
    localparam int MA_W = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic              cpu_req = 0, cpu_we = 0, cpu_burst = 0, posted_en = 0, closed_row_en = 0;
    logic [2*MA_W-1:0] cpu_addr = '0;
    logic              rfsh_req = 0, rfsh_four = 0;
    logic [1:0]        rfsh_kind = '0;
    logic              cpu_rdy, rfsh_ack, dram_ras_n, dram_cas_n, dram_we_n;
    logic [MA_W-1:0]   dram_ma;

    dram_burst_sequencer #(.MA_W(MA_W)) uut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_burst(cpu_burst),
        .cpu_addr(cpu_addr), .posted_en(posted_en), .closed_row_en(closed_row_en),
        .cpu_rdy(cpu_rdy), .rfsh_req(rfsh_req), .rfsh_kind(rfsh_kind),
        .rfsh_four(rfsh_four), .rfsh_ack(rfsh_ack), .dram_ras_n(dram_ras_n),
        .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_ma(dram_ma)
    );

    int total = 0;
    int bad = 0;
    bit bvalid = 0;
    logic [MA_W-1:0] brow = '0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_cpu(input bit we, input bit burst, input bit post, input bit closed,
                          input logic [MA_W-1:0] row, input logic [MA_W-1:0] col,
                          input bit already);
        int L, n, endc, raf, e_rdy, e_cas, e_ras, e_ma, e_we;
        bit hit;
        string tr;
        hit = 0;
        if (closed) L = 9;
        else if (!bvalid) L = we ? 11 : 10;
        else if (brow == row) begin L = we ? 10 : 6; hit = 1; end
        else L = we ? 13 : 12;
        n = burst ? 4 : 1;
        endc = L + 3 * (n - 1);
        raf = closed ? 4 : (hit ? 2 : L - 4);
        e_rdy = 0; e_cas = 0; e_ras = 0; e_ma = 0; e_we = 0;
        if (!already) begin
            cpu_req = 1; cpu_we = we; cpu_burst = burst; posted_en = post;
            closed_row_en = closed; cpu_addr = {row, col};
        end else begin
            @(negedge clk);
        end
        for (int c = 2; c <= endc + 1; c++) begin
            bit inb, er, ec, eras, ew;
            logic [1:0] q;
            logic [MA_W-1:0] ecol;
            @(negedge clk);
            if (c == 2) cpu_req = 0;
            inb = (c <= endc);
            ec = (c >= L) && ((c - L) % 3 == 0) && ((c - L) / 3 < n);
            er = (post && we) ? (c >= 4 && c < 4 + n) : ec;
            if (cpu_rdy !== er) e_rdy++;
            if ((!dram_cas_n) !== ec) e_cas++;
            eras = inb ? (hit ? 1'b1 : (c >= raf)) : !closed;
            if ((!dram_ras_n) !== eras) e_ras++;
            if (inb && c >= L - 1) begin
                q = col[1:0] ^ 2'((c - L + 1) / 3);
                ecol = {col[MA_W-1:2], q};
                if (dram_ma !== ecol) e_ma++;
            end
            if (c >= 2 && c == raf && dram_ma !== row) e_ma++;
            ew = we && inb;
            if ((!dram_we_n) !== ew) e_we++;
        end
        if (already) tr = "R12 ready after refresh";
        else if (post && we) tr = "R5 posted ready";
        else if (closed) tr = "R6 ready schedule";
        else if (we) tr = "R3 write ready R4";
        else tr = "R2 read ready R4";
        check(e_rdy == 0, tr, e_rdy, 0);
        check(e_cas == 0, "R4 column strobe beats", e_cas, 0);
        check(e_ras == 0, closed ? "R6 row strobe" : "R7 row strobe", e_ras, 0);
        check(e_ma == 0, "R8 R9 address", e_ma, 0);
        check(e_we == 0, "R14 write strobe", e_we, 0);
        if (closed) bvalid = 0;
        else begin bvalid = 1; brow = row; end
    endtask

    task automatic do_rfsh(input int kind, input bit four, input bit hold);
        int D, C, e_ack, e_str, e_rdy;
        D = (kind == 0) ? 16 : (kind == 1) ? 17 : 18;
        C = four ? 4 * D : D;
        e_ack = 0; e_str = 0; e_rdy = 0;
        rfsh_req = 1; rfsh_kind = 2'(kind); rfsh_four = four;
        for (int c = 2; c <= C; c++) begin
            bit er, ec;
            @(negedge clk);
            if (hold && c == 5) begin
                cpu_req = 1; cpu_we = 0; cpu_burst = 1; posted_en = 0; closed_row_en = 0;
                cpu_addr = {12'h3A5, 12'h0C2};
            end
            if (rfsh_ack !== (c == C)) e_ack++;
            if (cpu_rdy !== 1'b0) e_rdy++;
            if (c <= D) begin
                er = (c >= 3) && (c < D - 3);
                ec = (kind >= 2) && (c >= 2) && (c < D - 3);
                if ((!dram_ras_n) !== er) e_str++;
                if ((!dram_cas_n) !== ec) e_str++;
            end
            if (c == C) rfsh_req = 0;
        end
        check(e_ack == 0, four ? "R11 four-refresh acknowledge" : "R10 refresh acknowledge",
              e_ack, 0);
        check(e_str == 0, "R13 refresh strobes", e_str, 0);
        if (hold) check(e_rdy == 0, "R12 no ready during refresh", e_rdy, 0);
        bvalid = 0;
        if (!hold) @(negedge clk);
    endtask

    initial begin
        int g;
        g = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(dram_ras_n === 1'b1 && dram_cas_n === 1'b1 && dram_we_n === 1'b1,
              "R1 strobes idle after reset", {dram_ras_n, dram_cas_n, dram_we_n}, 7);
        check(cpu_rdy === 1'b0 && rfsh_ack === 1'b0, "R1 ready and ack low after reset",
              {cpu_rdy, rfsh_ack}, 0);

        for (int cl = 0; cl < 2; cl++)
            for (int we = 0; we < 2; we++)
                for (int po = 0; po < 2; po++)
                    for (int bu = 0; bu < 2; bu++) begin
                        logic [MA_W-1:0] ra;
                        if (po == 1 && we == 0) continue;
                        ra = 12'h100 + 12'(g);
                        do_cpu(we[0], bu[0], po[0], cl[0], ra, {10'(g), 2'(g)}, 0);
                        do_cpu(we[0], bu[0], po[0], cl[0], ra, {10'(g + 1), 2'(g + 1)}, 0);
                        do_cpu(we[0], bu[0], po[0], cl[0], ra + 12'h001,
                               {10'(g + 2), 2'(g + 3)}, 0);
                        g++;
                    end

        for (int k = 0; k < 4; k++)
            for (int f = 0; f < 2; f++) begin
                do_rfsh(k, f[0], 0);
                do_cpu(0, 1, 0, 0, 12'h055, 12'h013, 0);
                do_cpu(1, 0, 0, 0, 12'h055, 12'h021, 0);
            end

        do_rfsh(2, 0, 1);
        do_cpu(0, 1, 0, 0, 12'h3A5, 12'h0C2, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule